// File: doc/BRIEF.md
# Multichannel Swept-Sine Response Analyzer

This block measures response functions from inside a controller's logic. A free-running phase accumulator addresses a sine table and produces an excitation sample each clock. The sample is summed onto a feed-forward path so that it drives the controlled system, and it is exposed on its own port as well. Every channel takes one internal signal of the controller and correlates it against the sine and the cosine of the same excitation phase, summing both products over a programmed number of samples. The two sums form one complex response value per channel.

A start pulse arms one single-shot capture. All channels clear together, integrate the same sample window and then freeze, and a done flag is raised. The host selects a channel and a component through an index and reads the sums. It then divides complex values to normalise a point to the excitation or to an upstream point. When enabled by parameter, one extra channel integrates the excitation itself so that this division has a reference. Between one and fifteen channels can be built.

Top module: `nwa_top`

## Requirements
- R1: The excitation output `exc_o` is A·sin(2π·φ/2^32), where A = 2^(EXC_W−1)−1 and φ is a 32-bit phase that advances by `phase_inc` every clock. With `phase_inc` = 0 from reset the output stays 0. With `phase_inc` = 2^30 consecutive samples follow the cycle 0, A, 0, −A from any starting point.
- R2: `ff_out` equals the signed sum `ff_in + exc_o`, one bit wider than `ff_in`, with no register in the path.
- R3: For each external channel c the sine sum is Σ x_c·sin and the cosine sum is Σ x_c·cos over the window, where sin and cos are taken at the same phase as the concurrent `exc_o` sample. A constant input d with `phase_inc` = 0 gives a cosine sum of L·d·A and a sine sum of 0.
- R4: When HAS_REF = 1, channel index N_IN integrates `exc_o` itself. With `phase_inc` = 2^30 and L a multiple of 4 its sine sum is (L/2)·A² and its cosine sum is 0.
- R5: A start pulse clears every sum and lowers `done`. `done` rises at the L-th clock edge after the edge that takes start, and stays low in between. With L = 0, `done` rises at the edge that takes start and all sums read 0.
- R6: After `done`, all sums stay frozen until the next start, whatever the channel inputs do.
- R7: A start during a capture abandons it. Timing and sums then follow only the new start and its length.
- R8: Read-back is combinational. `rd_ch` selects a channel and `rd_sel` selects the component (0 = sine sum, 1 = cosine sum). An index of N_IN+HAS_REF or above returns 0.
- R9: A channel fed with `exc_o` delayed by D samples has a sine sum of about (L/2)·A²·cos(θ) and a cosine sum of about −(L/2)·A²·sin(θ), where θ = 2π·D·phase_inc/2^32. The cosine sum is therefore negative for a small positive delay. At quarter-turn steps the values are exact.
- R10: Sums are ACC_W = 48 bits signed and never wrap. The reference sine sum never decreases during a capture, and values beyond 32 bits read back exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that clears the sums and begins a capture |
| phase_inc | input | PH_W | Phase step per clock, which sets the excitation frequency |
| int_len | input | LEN_W | Number of samples to integrate, sampled at start |
| ff_in | input | DATA_W | Feed-forward sample, signed |
| ff_out | output | DATA_W+1 | Feed-forward plus excitation, signed |
| exc_o | output | EXC_W | Current excitation sample, signed |
| ch_in | input | N_IN*DATA_W | Signed channel inputs, channel c in bits c*DATA_W upward |
| rd_ch | input | clog2(N_IN+HAS_REF+1) | Read-back channel index |
| rd_sel | input | 1 | Read-back component: 0 sine sum, 1 cosine sum |
| rd_data | output | ACC_W | Selected sum, signed |
| done | output | 1 | Capture complete, cleared by start |

## Verification
The assertions check several behaviours on every cycle. Each start clears all sums at the next edge. Start lowers `done`, except with a zero length, where `done` rises immediately. `done` never coincides with an active capture. Sums do not move while idle. The reference sine sum never decreases while integrating. The bench scenarios are needed for the arithmetic: the exact sample count of a window, the values against constant and delayed-copy inputs at exact quarter-turn steps and at 64 samples per period, the restart and zero-length cases, the feed-forward sum and the out-of-range read-back.

// File: rtl/nwa_pkg.sv
`timescale 1ns/1ps
package nwa_pkg;

   typedef enum logic {COMP_SIN = 1'b0, COMP_COS = 1'b1} comp_e;

   // Integer sine point k of a 2^aw table, amplitude amp, rational approximation
   function automatic longint sine_pt(input int aw, input longint amp, input int k);
      longint h, kk, num, den, v;
      h   = longint'(1) << (aw - 1);
      kk  = longint'(k) % h;
      num = 16 * kk * (h - kk) * amp;
      den = 5 * h * h - 4 * kk * (h - kk);
      v   = num / den;
      return (longint'(k) >= h) ? -v : v;
   endfunction

endpackage

// File: rtl/nwa_nco.sv
`timescale 1ns/1ps
module nwa_nco #(
   parameter int PH_W   = 32,
   parameter int LUT_AW = 8,
   parameter int EXC_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [PH_W-1:0]         inc,
   output logic signed [EXC_W-1:0] sin_o,
   output logic signed [EXC_W-1:0] cos_o
);
   localparam int DEPTH = 1 << LUT_AW;
   localparam int QTR   = DEPTH / 4;
   localparam longint AMP = (longint'(1) << (EXC_W - 1)) - 1;

   generate
      if (LUT_AW < 2 || LUT_AW > PH_W || LUT_AW > 12) begin : g_bad_aw
         $error("nwa_nco: LUT_AW out of range");
      end
      if (EXC_W < 2 || EXC_W > 31) begin : g_bad_w
         $error("nwa_nco: EXC_W out of range");
      end
   endgenerate

   logic [PH_W-1:0]         ph;
   logic [LUT_AW-1:0]       idx_s, idx_c;
   logic signed [EXC_W-1:0] tbl [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
         localparam longint PT = nwa_pkg::sine_pt(LUT_AW, AMP, g);
         assign tbl[g] = EXC_W'(PT);
      end
   endgenerate

   assign idx_s = ph[PH_W-1 -: LUT_AW];
   assign idx_c = idx_s + LUT_AW'(QTR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph    <= '0;
         sin_o <= '0;
         cos_o <= '0;
      end else begin
         ph    <= ph + inc;
         sin_o <= tbl[idx_s];
         cos_o <= tbl[idx_c];
      end
   end
endmodule

// File: rtl/nwa_ctrl.sv
`timescale 1ns/1ps
module nwa_ctrl #(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] len,
   output logic             clr,
   output logic             acc_en,
   output logic             busy,
   output logic             done
);
   logic [LEN_W-1:0] cnt;

   assign clr    = start;
   assign acc_en = busy && !start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else if (start) begin
         cnt  <= len;
         busy <= (len != '0);
         done <= (len == '0);
      end else if (busy) begin
         cnt <= cnt - LEN_W'(1);
         if (cnt == LEN_W'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/nwa_chan.sv
`timescale 1ns/1ps
module nwa_chan #(
   parameter int DATA_W = 16,
   parameter int EXC_W  = 16,
   parameter int ACC_W  = 48
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     en,
   input  logic signed [DATA_W-1:0] x,
   input  logic signed [EXC_W-1:0]  s,
   input  logic signed [EXC_W-1:0]  c,
   output logic signed [ACC_W-1:0]  acc_s,
   output logic signed [ACC_W-1:0]  acc_c
);
   localparam int PW = DATA_W + EXC_W;

   logic signed [PW-1:0] prod_s, prod_c;

   assign prod_s = x * s;
   assign prod_c = x * c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_s <= '0;
         acc_c <= '0;
      end else if (clr) begin
         acc_s <= '0;
         acc_c <= '0;
      end else if (en) begin
         acc_s <= acc_s + ACC_W'(prod_s);
         acc_c <= acc_c + ACC_W'(prod_c);
      end
   end
endmodule

// File: rtl/nwa_top.sv
`timescale 1ns/1ps
module nwa_top
   import nwa_pkg::*;
#(
   parameter int PH_W    = 32,
   parameter int LUT_AW  = 8,
   parameter int EXC_W   = 16,
   parameter int DATA_W  = 16,
   parameter int LEN_W   = 16,
   parameter int ACC_W   = 48,
   parameter int N_IN    = 3,
   parameter int HAS_REF = 1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                start,
   input  logic [PH_W-1:0]                     phase_inc,
   input  logic [LEN_W-1:0]                    int_len,
   input  logic signed [DATA_W-1:0]            ff_in,
   output logic signed [DATA_W:0]              ff_out,
   output logic signed [EXC_W-1:0]             exc_o,
   input  logic [N_IN*DATA_W-1:0]              ch_in,
   input  logic [$clog2(N_IN+HAS_REF+1)-1:0]   rd_ch,
   input  logic                                rd_sel,
   output logic signed [ACC_W-1:0]             rd_data,
   output logic                                done
);
   localparam int NCH   = N_IN + HAS_REF;
   localparam int RD_AW = $clog2(NCH + 1);

   generate
      if (N_IN < 1 || NCH > 15) begin : g_bad_n
         $error("nwa_top: channel count out of range");
      end
      if (HAS_REF != 0 && HAS_REF != 1) begin : g_bad_ref
         $error("nwa_top: HAS_REF must be 0 or 1");
      end
      if (EXC_W > DATA_W) begin : g_bad_exc
         $error("nwa_top: EXC_W must not exceed DATA_W");
      end
      if (ACC_W < DATA_W + EXC_W + LEN_W - 1 || ACC_W > 62) begin : g_bad_acc
         $error("nwa_top: ACC_W too small for a full-length capture");
      end
   endgenerate

   logic signed [EXC_W-1:0]  exc_s, exc_c;
   logic                     clr, acc_en, busy;
   logic signed [ACC_W-1:0]  acc_s [NCH];
   logic signed [ACC_W-1:0]  acc_c [NCH];
   logic [NCH*2*ACC_W-1:0]   acc_flat;
   logic signed [ACC_W-1:0]  ref_mon;

   nwa_nco #(.PH_W(PH_W), .LUT_AW(LUT_AW), .EXC_W(EXC_W)) u_nco (
      .clk(clk), .rst_n(rst_n), .inc(phase_inc), .sin_o(exc_s), .cos_o(exc_c)
   );

   nwa_ctrl #(.LEN_W(LEN_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .len(int_len),
      .clr(clr), .acc_en(acc_en), .busy(busy), .done(done)
   );

   assign exc_o  = exc_s;
   assign ff_out = (DATA_W+1)'(ff_in) + (DATA_W+1)'(exc_s);

   generate
      for (genvar g = 0; g < N_IN; g++) begin : g_ext
         logic signed [DATA_W-1:0] xg;
         assign xg = ch_in[g*DATA_W +: DATA_W];
         nwa_chan #(.DATA_W(DATA_W), .EXC_W(EXC_W), .ACC_W(ACC_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .clr(clr), .en(acc_en), .x(xg),
            .s(exc_s), .c(exc_c), .acc_s(acc_s[g]), .acc_c(acc_c[g])
         );
      end
      if (HAS_REF != 0) begin : g_ref
         logic signed [DATA_W-1:0] xr;
         assign xr = DATA_W'(exc_s);
         nwa_chan #(.DATA_W(DATA_W), .EXC_W(EXC_W), .ACC_W(ACC_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .clr(clr), .en(acc_en), .x(xr),
            .s(exc_s), .c(exc_c), .acc_s(acc_s[N_IN]), .acc_c(acc_c[N_IN])
         );
         assign ref_mon = acc_s[N_IN];
      end else begin : g_noref
         assign ref_mon = '0;
      end
      for (genvar g = 0; g < NCH; g++) begin : g_flat
         assign acc_flat[g*2*ACC_W +: 2*ACC_W] = {acc_c[g], acc_s[g]};
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int c = 0; c < NCH; c++) begin
         if (rd_ch == RD_AW'(c))
            rd_data = (rd_sel == COMP_COS) ? acc_c[c] : acc_s[c];
      end
   end
endmodule

// File: rtl/nwa_chk.sv
`timescale 1ns/1ps
module nwa_chk #(
   parameter int ACC_W = 48,
   parameter int NCH   = 4,
   parameter int LEN_W = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start,
   input logic [LEN_W-1:0]        int_len,
   input logic                    busy,
   input logic                    done,
   input logic signed [ACC_W-1:0] ref_mon,
   input logic [NCH*2*ACC_W-1:0]  acc_flat
);
   // R3: every start leaves all sums at zero
   p_start_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (acc_flat == '0));

   // R5: start with a nonzero length lowers done
   p_done_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && int_len != '0) |=> !done);

   // R5: start with zero length finishes at once
   p_len_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && int_len == '0) |=> done);

   // R5: done never overlaps an active capture
   p_busy_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);

   // R6: sums hold while no capture runs
   p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(acc_flat));

   // R10: reference sine sum of squares never drops (no wrap)
   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start) |=> (ref_mon >= $past(ref_mon)));
endmodule

bind nwa_top nwa_chk #(.ACC_W(ACC_W), .NCH(N_IN + HAS_REF), .LEN_W(LEN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .int_len(int_len),
   .busy(busy), .done(done), .ref_mon(ref_mon), .acc_flat(acc_flat)
);

// File: tb/tb_nwa_top.sv
`timescale 1ns/1ps
module tb_nwa_top;
   localparam int NI = 3;
   localparam longint A = 32767;
   localparam longint A2 = A * A;
   localparam real PI = 3.14159265358979;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic [31:0]        phase_inc = '0;
   logic [15:0]        int_len = '0;
   logic signed [15:0] ff_in = '0;
   logic signed [16:0] ff_out;
   logic signed [15:0] exc_o;
   logic [NI*16-1:0]   ch_in;
   logic [2:0]         rd_ch = '0;
   logic               rd_sel = 1'b0;
   logic signed [47:0] rd_data;
   logic               done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic signed [15:0] hist [0:31];
   int                 dly [NI];
   logic signed [15:0] dcv [NI];

   always #10 clk = ~clk;

   nwa_top #(.N_IN(NI), .HAS_REF(1)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .phase_inc(phase_inc),
      .int_len(int_len), .ff_in(ff_in), .ff_out(ff_out), .exc_o(exc_o),
      .ch_in(ch_in), .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data),
      .done(done)
   );

   always @(negedge clk) begin
      for (int i = 31; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = exc_o;
      for (int c = 0; c < NI; c++)
         ch_in[c*16 +: 16] = (dly[c] < 0) ? dcv[c] : hist[dly[c]];
   end

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_near(input string req, input longint act, input real exp, input real tol);
      real d;
      checks++;
      d = $itor(act) - exp;
      if (d < 0.0) d = -d;
      if (d > tol) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0f", req, act, exp);
      end
   endtask

   task automatic rd(input int ch, input bit sel, output longint v);
      @(negedge clk);
      rd_ch = 3'(ch);
      rd_sel = sel;
      #1;
      v = longint'(rd_data);
   endtask

   // start pulse, count clock edges until done
   task automatic run(input int len, output int n);
      @(negedge clk);
      int_len = 16'(len);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      if (len > 0) chk("R5 done low after start", longint'(done), 0);
      while (!done && n < 70000) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      int n;
      longint v, s0, c0;
      real S, ph;
      logic signed [15:0] e [8];
      for (int c = 0; c < NI; c++) begin dly[c] = -1; dcv[c] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      ff_in = 16'sd5;
      @(negedge clk);
      #1;
      // reset state
      chk("R5 reset done", longint'(done), 0);
      chk("R1 reset exc", longint'(exc_o), 0);
      chk("R2 ff at zero exc", longint'(ff_out), 5);
      rd(0, 1'b1, v);
      chk("R8 reset read", v, 0);

      // constant inputs, phase_inc 0
      dcv[0] = 16'sd1000; dcv[1] = -16'sd7; dcv[2] = 16'sd32767;
      repeat (3) @(negedge clk);
      run(10, n);
      chk("R5 sample count L=10", n, 10);
      chk("R1 exc stays zero", longint'(exc_o), 0);
      rd(0, 1'b1, v); chk("R3 ch0 cos", v, 10 * 1000 * A);
      rd(0, 1'b0, v); chk("R3 ch0 sin", v, 0);
      rd(1, 1'b1, v); chk("R3 ch1 cos", v, -10 * 7 * A);
      rd(2, 1'b1, v); chk("R3 ch2 cos", v, 10 * A * A);
      rd(3, 1'b1, v); chk("R4 ref cos inc0", v, 0);

      // freeze after done
      dcv[0] = 16'sd3; dcv[1] = 16'sd3; dcv[2] = 16'sd3;
      repeat (6) @(negedge clk);
      rd(0, 1'b1, v); chk("R6 ch0 frozen", v, 10 * 1000 * A);
      rd(2, 1'b1, v); chk("R6 ch2 frozen", v, 10 * A * A);
      chk("R6 done held", longint'(done), 1);

      // restart during a capture
      @(negedge clk);
      int_len = 16'd100; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (30) @(negedge clk);
      chk("R7 still busy", longint'(done), 0);
      run(50, n);
      chk("R7 count from new start", n, 50);
      rd(0, 1'b1, v); chk("R7 sum from new start", v, 50 * 3 * A);

      // read-back range
      for (int ch = 4; ch < 8; ch++) begin
         rd(ch, 1'b1, v); chk("R8 out of range cos", v, 0);
         rd(ch, 1'b0, v); chk("R8 out of range sin", v, 0);
      end

      // zero length
      run(0, n);
      chk("R5 zero length count", n, 0);
      chk("R5 zero length done", longint'(done), 1);
      rd(0, 1'b1, v); chk("R5 zero length sums", v, 0);

      // quarter-turn steps
      phase_inc = 32'h4000_0000;
      repeat (4) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         e[i] = exc_o;
      end
      for (int i = 0; i < 6; i++) begin
         chk("R1 half-turn negation", longint'(e[i+2]), -longint'(e[i]));
         chk("R1 quarter amplitude",
             ((e[i] < 0) ? -longint'(e[i]) : longint'(e[i])) +
             ((e[i+1] < 0) ? -longint'(e[i+1]) : longint'(e[i+1])), A);
      end
      dly[0] = 1; dly[1] = 2; dly[2] = 3;
      repeat (40) @(negedge clk);
      run(4096, n);
      chk("R5 count L=4096", n, 4096);
      rd(3, 1'b0, v); chk("R4 ref sin exact", v, 2048 * A2);
      rd(3, 1'b1, v); chk("R4 ref cos exact", v, 0);
      rd(0, 1'b1, v); chk("R9 delay1 cos", v, -2048 * A2);
      rd(0, 1'b0, v); chk("R9 delay1 sin", v, 0);
      rd(1, 1'b0, v); chk("R10 delay2 sin beyond 32 bits", v, -2048 * A2);
      rd(1, 1'b1, v); chk("R9 delay2 cos", v, 0);
      rd(2, 1'b1, v); chk("R9 delay3 cos", v, 2048 * A2);

      // 64 samples per period, feed-forward sum while exciting
      phase_inc = 32'h0400_0000;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         ff_in = (i == 0) ? 16'sh7fff : (i == 1) ? 16'sh8000 : 16'(i * 1234 - 3000);
         #1;
         chk("R2 ff sum", longint'(ff_out), longint'(ff_in) + longint'(exc_o));
      end
      dly[0] = 1; dly[1] = 8; dly[2] = 16;
      repeat (40) @(negedge clk);
      run(640, n);
      S = 320.0 * $itor(A2);
      for (int c = 0; c < NI; c++) begin
         ph = 2.0 * PI * $itor(dly[c]) / 64.0;
         rd(c, 1'b0, s0);
         rd(c, 1'b1, c0);
         chk_near("R9 delayed sin sum", s0, S * $cos(ph), 0.01 * S);
         chk_near("R9 delayed cos sum", c0, -S * $sin(ph), 0.01 * S);
         chk("R9 cos sum negative", longint'(c0 < 0), 1);
      end
      rd(3, 1'b0, v); chk_near("R4 ref sin 64pt", v, S, 0.01 * S);
      rd(3, 1'b1, v); chk_near("R4 ref cos 64pt", v, 0.0, 0.01 * S);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule